// File: doc/BRIEF.md
# Prescaled Serial-Clock Waveform Generator

This block turns a fast input clock into the timing base for a two-wire serial bus master. A programmable 8-bit divisor slows the input clock down to a module clock, which appears as a single-cycle tick. A phase shaper counts those ticks to drive the serial clock line low for one programmed count and high for a second, independently programmed count. Clock stretching, arbitration and the protocol sequencer are handled elsewhere. Those functions see only the tick and the SCL drive level.

Software writes the divisor through a small register write port at any time. The working copy of the divisor is taken only at the moment the module-run bit goes from 0 to 1, so a write made while the module runs is visible on readback but does not change the tick period. The low-time and high-time counts are latched at the start of each phase. A change to either count therefore takes effect at the next phase boundary.

Top module: `scl_clkgen`

## Requirements
- R1: A write with `wr_sel` = 2'b00 stores `wr_data[7:0]` as the prescale value. `psc_rd` returns that value in bits 7:0 and zero in bits 15:8, whatever was written to `wr_data[15:8]`.
- R2: Let N be the captured prescale value and let edge 0 be the first rising edge that samples `mod_run` = 1. `tick` is high in the cycle after edge N and again every N+1 cycles after that. With N = 0, `tick` is high in every cycle.
- R3: A prescale write while `mod_run` = 1 changes `psc_rd` but not the tick period. The new value is used only after `mod_run` next goes from 0 to 1.
- R4: While `mod_run` = 0, `tick` is low, `scl` is high, and the prescale and phase counters are held at zero.
- R5: Writes with `wr_sel` = 2'b01 set the low count L, and writes with `wr_sel` = 2'b10 set the high count H. `scl` stays low for L+1 tick periods and then high for H+1 tick periods.
- R6: The low and high counts are latched when their phase begins. A write during a phase takes effect from the next phase of that kind.
- R7: `scl` changes only on a clock edge that samples `tick` high. The first low phase starts at the first such edge that also samples `mst_en` = 1.
- R8: After `mst_en` falls, the generator finishes the current low phase, if one is running, and the following high phase. `scl` then stays high.
- R9: A synchronous reset (`rst_n` = 0) clears all three registers and the divisor, sets `scl` high and `tick` low, and reads back zero.
- R10: Writes with `wr_sel` = 2'b11 change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 00 prescale, 01 low count, 10 high count, 11 unused |
| wr_data | input | 16 | Write data |
| mod_run | input | 1 | Module run bit; 0 holds the block in reset, 0-to-1 captures the divisor |
| mst_en | input | 1 | Master enable for SCL generation |
| tick | output | 1 | Module clock tick, one input-clock cycle wide |
| scl | output | 1 | SCL drive level |
| psc_rd | output | 16 | Prescale register readback |

## Verification
All results are indexed by k, the number of rising edges since the edge that first samples `mod_run` = 1. `tick` is due in the cycle after edge k when k - N is a non-negative multiple of N+1. `scl` follows one edge later than the tick that moves it. Counting the ticks seen at edges up to k-1 and taking that count modulo L+H+2 gives the expected level. The bench drives every input on the falling edge and samples on the falling edge after each rising edge. Each expected value is therefore a closed-form function of k and never depends on the order of processes at an edge. Register readback is due in the cycle after the write edge and is sampled there.

// File: rtl/sclgen_pkg.sv
// Shared types for the prescaled serial-clock generator.
// Assumes: the register select and phase encodings below are used by all submodules.
package sclgen_pkg;

    // Register select codes on the write port
    typedef enum logic [1:0] {
        SEL_PSC  = 2'b00,
        SEL_LOW  = 2'b01,
        SEL_HIGH = 2'b10,
        SEL_NONE = 2'b11
    } reg_sel_e;

    // Phase of the SCL waveform
    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_LOW  = 2'b01,
        PH_HIGH = 2'b10
    } phase_e;

endpackage

// File: rtl/sclgen_regs.sv
// Register bank: prescale value, low count and high count, with prescale readback.
// Assumes: CNT_W <= REG_W and PSC_W < REG_W; the unused select code writes nothing.
module sclgen_regs
    import sclgen_pkg::*;
#(
    parameter int PSC_W = 8,
    parameter int REG_W = 16,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [REG_W-1:0] wr_data,
    output logic [PSC_W-1:0] psc_q,
    output logic [CNT_W-1:0] low_q,
    output logic [CNT_W-1:0] high_q,
    output logic [REG_W-1:0] psc_rd
);

    localparam int PAD_W = REG_W - PSC_W;

    reg_sel_e sel;
    assign sel = reg_sel_e'(wr_sel);

    // Store a write into the selected register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psc_q  <= '0;
            low_q  <= '0;
            high_q <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_PSC:  psc_q  <= wr_data[PSC_W-1:0];
                SEL_LOW:  low_q  <= wr_data[CNT_W-1:0];
                SEL_HIGH: high_q <= wr_data[CNT_W-1:0];
                default:  ;
            endcase
        end
    end

    // Readback pads the upper bits with zero
    assign psc_rd = {{PAD_W{1'b0}}, psc_q};

    // R1: a prescale write is stored and visible the next cycle
    assert_psc_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'b00) |=> (psc_q == $past(wr_data[PSC_W-1:0])));

    // R10: the unused select code leaves every register unchanged
    assert_spare_sel_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'b11) |=> ($stable(psc_q) && $stable(low_q) && $stable(high_q)));

endmodule

// File: rtl/sclgen_div.sv
// Prescaler: produces one tick every (divisor + 1) input clocks.
// Assumes: the divisor is captured from psc_in only on the cycle mod_run rises;
// while mod_run is 0 the counter is held at zero and no tick is produced.
module sclgen_div #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mod_run,
    input  logic [PSC_W-1:0] psc_in,
    output logic             tick
);

    logic             run_q;
    logic [PSC_W-1:0] div_q;
    logic [PSC_W-1:0] cnt_q;

    // Delay mod_run by one cycle to find its rising edge
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= mod_run;
    end

    // Capture the working divisor when the module leaves reset
    always_ff @(posedge clk) begin
        if (!rst_n)                 div_q <= '0;
        else if (mod_run && !run_q) div_q <= psc_in;
    end

    // Count input clocks, wrapping at the working divisor
    always_ff @(posedge clk) begin
        if (!rst_n || !mod_run) cnt_q <= '0;
        else if (!run_q)        cnt_q <= '0;
        else if (cnt_q == div_q) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    assign tick = run_q && (cnt_q == div_q);

    // R2: two ticks in a row only with a divisor of zero
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (!tick || div_q == '0));

    // R2: the counter never passes the working divisor
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (cnt_q <= div_q));

    // R3: the working divisor is frozen while the module runs
    assert_div_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && mod_run) |=> $stable(div_q));

    // R4: held in reset means a zero counter and no tick
    assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_run |=> (cnt_q == '0 && !tick));

endmodule

// File: rtl/sclgen_shape.sv
// Phase shaper: drives SCL low for (low+1) ticks and high for (high+1) ticks.
// Assumes: advances only on ticks; each count is latched at the start of its phase;
// when mst_en falls the cycle finishes with its high phase, then SCL rests high.
module sclgen_shape
    import sclgen_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mod_run,
    input  logic             mst_en,
    input  logic             tick,
    input  logic [CNT_W-1:0] low_cnt,
    input  logic [CNT_W-1:0] high_cnt,
    output logic             scl
);

    phase_e           state;
    logic [CNT_W-1:0] pcnt;
    logic [CNT_W-1:0] len_q;
    logic             last;

    assign last = (pcnt == len_q);

    // Step the phase machine on each tick
    always_ff @(posedge clk) begin
        if (!rst_n || !mod_run) begin
            state <= PH_IDLE;
            pcnt  <= '0;
            len_q <= '0;
        end else if (tick) begin
            case (state)
                PH_IDLE: begin
                    if (mst_en) begin
                        state <= PH_LOW;
                        len_q <= low_cnt;
                    end
                    pcnt <= '0;
                end
                PH_LOW: begin
                    if (last) begin
                        state <= PH_HIGH;
                        len_q <= high_cnt;
                        pcnt  <= '0;
                    end else begin
                        pcnt <= pcnt + 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (last) begin
                        state <= mst_en ? PH_LOW : PH_IDLE;
                        len_q <= mst_en ? low_cnt : '0;
                        pcnt  <= '0;
                    end else begin
                        pcnt <= pcnt + 1'b1;
                    end
                end
                default: begin
                    state <= PH_IDLE;
                    pcnt  <= '0;
                end
            endcase
        end
    end

    assign scl = (state != PH_LOW);

    // R7: SCL only moves on an edge that samples a tick
    assert_tick_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_run && !tick) |=> $stable(scl));

    // R4: held in reset means SCL high
    assert_idle_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_run |=> scl);

    // R8: once resting with the enable low, the shaper stays at rest
    assert_rest_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_IDLE && !mst_en) |=> (state == PH_IDLE));

    // R5: the phase counter never runs past the latched length
    assert_phase_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state != PH_IDLE) |-> (pcnt <= len_q));

endmodule

// File: rtl/scl_clkgen.sv
// Top: register bank, prescaler and SCL phase shaper.
// Assumes: synchronous active-low reset; mod_run = 0 holds the datapath idle.
module scl_clkgen #(
    parameter int PSC_W = 8,
    parameter int REG_W = 16,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic             mod_run,
    input  logic             mst_en,
    output logic             tick,
    output logic             scl,
    output logic [REG_W-1:0] psc_rd
);

    logic [PSC_W-1:0] psc_q;
    logic [CNT_W-1:0] low_q;
    logic [CNT_W-1:0] high_q;

    sclgen_regs #(.PSC_W(PSC_W), .REG_W(REG_W), .CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .psc_q   (psc_q),
        .low_q   (low_q),
        .high_q  (high_q),
        .psc_rd  (psc_rd)
    );

    sclgen_div #(.PSC_W(PSC_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .mod_run (mod_run),
        .psc_in  (psc_q),
        .tick    (tick)
    );

    sclgen_shape #(.CNT_W(CNT_W)) u_shape (
        .clk      (clk),
        .rst_n    (rst_n),
        .mod_run  (mod_run),
        .mst_en   (mst_en),
        .tick     (tick),
        .low_cnt  (low_q),
        .high_cnt (high_q),
        .scl      (scl)
    );

endmodule

// File: tb/sim_scl_clkgen.sv
`timescale 1ns/1ps
module sim_scl_clkgen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'b00;
    logic [15:0] wr_data = '0;
    logic        mod_run = 1'b0;
    logic        mst_en = 1'b0;
    logic        tick;
    logic        scl;
    logic [15:0] psc_rd;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    scl_clkgen u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .mod_run(mod_run), .mst_en(mst_en), .tick(tick), .scl(scl), .psc_rd(psc_rd)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // One register write, driven on falling edges
    task automatic wr(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic bit exp_tick(int k, int n);
        return (k >= n) && (((k - n) % (n + 1)) == 0);
    endfunction

    function automatic bit exp_scl(int k, int n, int l, int h);
        int c;
        c = (k - 1 >= n) ? ((k - 1 - n) / (n + 1) + 1) : 0;
        if (c == 0) return 1'b1;
        return ((c - 1) % (l + h + 2)) >= (l + 1);
    endfunction

    // Hold the module idle, program it, then start it with the master enable high
    task automatic start(input int n, input int l, input int h);
        @(negedge clk);
        mod_run = 1'b0; mst_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R4 idle scl", scl, 1);
        chk("R4 idle tick", tick, 0);
        wr(2'b00, 16'(n));
        wr(2'b01, 16'(l));
        wr(2'b10, 16'(h));
        chk("R1 readback", psc_rd, n);
        mod_run = 1'b1; mst_en = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: state after reset
        chk("R9 reset readback", psc_rd, 0);
        chk("R9 reset scl", scl, 1);
        chk("R9 reset tick", tick, 0);
        rst_n = 1'b1;

        // R1 / R10: upper bits dropped, spare select ignored
        wr(2'b00, 16'hAB12);
        chk("R1 upper bits zero", psc_rd, 16'h0012);
        wr(2'b11, 16'hFFFF);
        chk("R10 spare select", psc_rd, 16'h0012);

        // R2 / R5 / R7: sweep of divisor and phase counts
        for (int n = 0; n < 4; n++) begin
            for (int l = 0; l < 3; l++) begin
                for (int h = 0; h < 3; h += 2) begin
                    start(n, l, h);
                    for (int k = 0; k <= 2 * (l + h + 2) * (n + 1) + n + 2; k++) begin
                        @(negedge clk);
                        chk("R2 tick", tick, exp_tick(k, n));
                        chk("R5 R7 scl", scl, exp_scl(k, n, l, h));
                    end
                end
            end
        end

        // R10: spare-select write must not disturb the low/high counts (1,1)
        @(negedge clk); mod_run = 1'b0; mst_en = 1'b0;
        wr(2'b00, 16'd0); wr(2'b01, 16'd1); wr(2'b10, 16'd1);
        wr(2'b11, 16'h00FF);
        mod_run = 1'b1; mst_en = 1'b1;
        for (int k = 0; k <= 12; k++) begin
            @(negedge clk);
            chk("R10 counts kept", scl, exp_scl(k, 0, 1, 1));
        end

        // R3: prescale write while running does not change the period
        start(1, 0, 0);
        for (int k = 0; k <= 14; k++) begin
            @(negedge clk);
            if (k == 2) begin wr_en = 1'b1; wr_sel = 2'b00; wr_data = 16'd3; end
            if (k == 3) begin wr_en = 1'b0; chk("R3 readback while running", psc_rd, 3); end
            chk("R3 old period kept", tick, exp_tick(k, 1));
        end
        @(negedge clk); mod_run = 1'b0;
        @(negedge clk);
        chk("R4 tick on hold", tick, 0);
        mod_run = 1'b1;
        for (int k = 0; k <= 14; k++) begin
            @(negedge clk);
            chk("R3 new period after restart", tick, exp_tick(k, 3));
        end

        // R6: low count rewritten during the first low phase
        start(0, 1, 1);
        for (int k = 0; k <= 14; k++) begin
            @(negedge clk);
            chk("R6 scl", scl, ((k >= 1 && k <= 2) || (k >= 5 && k <= 8) || k >= 11) ? 0 : 1);
            if (k == 1) begin wr_en = 1'b1; wr_sel = 2'b01; wr_data = 16'd3; end
            if (k == 2) wr_en = 1'b0;
        end

        // R8: enable dropped at the start of a low phase
        start(0, 1, 1);
        for (int k = 0; k <= 20; k++) begin
            @(negedge clk);
            if (k <= 5) chk("R8 before release", scl, exp_scl(k, 0, 1, 1));
            else        chk("R8 finish and rest", scl, (k <= 6) ? 0 : 1);
            if (k == 5) mst_en = 1'b0;
        end

        // R9: reset while running
        start(2, 1, 1);
        repeat (7) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 mid-run readback", psc_rd, 0);
        chk("R9 mid-run scl", scl, 1);
        chk("R9 mid-run tick", tick, 0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule